// File: doc/BRIEF.md
# SDRAM Initialization Mode Command Sequencer

This block sits between a processor-side request port and the command pins of a single data rate SDRAM. A three-bit mode field, written by software through a small register port, decides what each processor access turns into on the memory bus. In the initialization modes an access produces exactly one special command: a no-operation, a precharge of all banks, a mode register load, or an auto (CBR) refresh. In normal mode an access becomes a read or a write. No data moves through the block. The block acknowledges the host in the same cycle that the command appears on the pins.

The block also owns the clock-enable outputs. They stay low through reset and after it, until software first writes a non-zero mode. A low-power request makes the block finish any access it has already accepted. It then issues a refresh with clock-enable dropped in the same cycle, which puts every row into self-refresh. When the request is withdrawn, the block raises clock-enable, holds a fixed run of NOP cycles, and then returns to normal operation with no software involvement. A resume that passes through reset leaves the mode at 000 and clock-enable low, so software must run initialization again.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset the mode reads 000, every clock-enable bit is low, the command pins show deselect {csN,rasN,casN,weN}=1111, and hostAck is low.
- R2: The register read value carries the mode in bits [2:0]. Bits [5:4] form a read-only memory-type field that always reads 00 (SDR), and writes to it are ignored. All other bits read 0.
- R3: Clock-enable stays low after reset until a write puts a non-zero value in the mode bits. From the cycle after that write, all clock-enable bits are high together.
- R4: While the mode is 000, host requests are stalled: no acknowledge, and the command pins stay at deselect.
- R5: In mode 001 an access issues NOP (0111) with address 0.
- R6: In mode 010 an access issues precharge (0010) with address bit 10 set and every other address bit clear.
- R7: In mode 011 an access issues mode-register-set (0000), and the memory address equals host address bits [15:3].
- R8: In mode 110 an access issues refresh (0001) with address 0.
- R9: In mode 111 an access issues read (0101) when hostWe is 0 and write (0100) when hostWe is 1, with the memory address equal to host address bits [15:3].
- R10: Modes 100 and 101 behave exactly like mode 001.
- R11: Every accepted access drives its command for exactly one cycle. hostAck is high in that same cycle, and the pins return to deselect in the next cycle.
- R12: When lpReq rises in an idle cycle with clock-enable high, the next cycle shows refresh (0001) with clock-enable low. Clock-enable then stays low and the pins stay at deselect, and host requests are stalled, for as long as lpReq is held.
- R13: After lpReq falls, clock-enable is high from the next cycle on, the pins show NOP for EXIT_CYC cycles, and a pending host request is then accepted.
- R14: A reset taken during self-refresh leaves the mode at 000 and clock-enable low after reset, including when lpReq is then removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data; the mode is in [2:0] |
| regRdData | output | 8 | Register read value: mode in [2:0], memory type in [5:4] |
| hostReq | input | 1 | Host access request, held until acknowledged |
| hostWe | input | 1 | Host access is a write |
| hostAddr | input | ADDR_W | Host address |
| hostAck | output | 1 | One-cycle acknowledge, coincident with the command |
| lpReq | input | 1 | Low-power (self-refresh) request level |
| memCsN | output | 1 | SDRAM chip select, active low |
| memRasN | output | 1 | SDRAM row strobe, active low |
| memCasN | output | 1 | SDRAM column strobe, active low |
| memWeN | output | 1 | SDRAM write enable, active low |
| memAddr | output | MA_W | SDRAM address lines |
| memCke | output | CKE_W | SDRAM clock-enable bits |

## Verification
The bench targets the stall in mode 000 and the exact cycle in which clock-enable rises after the first non-zero write. A design that gated clock-enable on the raw register value instead of a sticky flag would drop it again when 000 is written back. A design that acknowledged in mode 000 would send commands to an SDRAM that is not clocked. The reserved codes are checked to give NOP and not a stray read or refresh. The mode-register load is checked against a shifted address, which catches an off-by-one slice. The self-refresh tests count the exact cycle of the refresh relative to the clock-enable drop, and the length of the NOP run on exit. They also confirm that a request held through self-refresh is neither lost nor issued early, and that a reset in self-refresh does not re-enable clock-enable.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    CMD_MRS   = 4'b0000,
    CMD_REF   = 4'b0001,
    CMD_PRE   = 4'b0010,
    CMD_WR    = 4'b0100,
    CMD_RD    = 4'b0101,
    CMD_NOP   = 4'b0111,
    CMD_DESEL = 4'b1111
  } sdCmd_e;

  typedef enum logic [1:0] {
    ADDR_ZERO,
    ADDR_A10,
    ADDR_HOST
  } addrSel_e;

  localparam logic [2:0] MODE_RESET = 3'b000;
  localparam logic [2:0] MODE_NOP   = 3'b001;
  localparam logic [2:0] MODE_PRE   = 3'b010;
  localparam logic [2:0] MODE_MRS   = 3'b011;
  localparam logic [2:0] MODE_REF   = 3'b110;
  localparam logic [2:0] MODE_RUN   = 3'b111;

  localparam logic [1:0] MEM_TYPE_SDR = 2'b00;

  // control -> datapath strobes
  typedef struct packed {
    sdCmd_e   cmd;
    addrSel_e addrSel;
    logic     ckeLow;
  } ctrlStrobe_t;

endpackage

// File: rtl/sis_datapath.sv
module sis_datapath
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int MA_W   = 13,
  parameter int CKE_W  = 2,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  input  logic [ADDR_W-1:0] hostAddr,
  input  ctrlStrobe_t       strobe,
  output logic [2:0]        modeVal,
  output logic [REG_W-1:0]  regRdData,
  output logic [3:0]        cmdOut,
  output logic [MA_W-1:0]   memAddr,
  output logic [CKE_W-1:0]  memCke
);

  localparam int HOST_LSB = 3;
  localparam int HOST_MSB = HOST_LSB + MA_W - 1;
  localparam logic [MA_W-1:0] A10_ONLY = MA_W'(1) << 10;

  logic [2:0]      modeReg;
  logic            ckeOn;
  logic [3:0]      cmdReg;
  logic [MA_W-1:0] addrReg;
  logic [MA_W-1:0] addrNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= MODE_RESET;
      ckeOn   <= 1'b0;
    end else if (regWrEn) begin
      modeReg <= regWrData[2:0];
      if (regWrData[2:0] != MODE_RESET) ckeOn <= 1'b1;
    end
  end

  always_comb begin
    unique case (strobe.addrSel)
      ADDR_A10:  addrNext = A10_ONLY;
      ADDR_HOST: addrNext = hostAddr[HOST_MSB:HOST_LSB];
      default:   addrNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg  <= CMD_DESEL;
      addrReg <= '0;
    end else begin
      cmdReg  <= strobe.cmd;
      addrReg <= addrNext;
    end
  end

  always_comb begin
    regRdData      = '0;
    regRdData[2:0] = modeReg;
    regRdData[5:4] = MEM_TYPE_SDR;
  end

  assign modeVal = modeReg;
  assign cmdOut  = cmdReg;
  assign memAddr = addrReg;
  assign memCke  = {CKE_W{ckeOn & ~strobe.ckeLow}};

endmodule

// File: rtl/sis_ctrl.sv
module sis_ctrl
  import sdram_init_pkg::*;
#(
  parameter int EXIT_CYC = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  modeVal,
  input  logic        hostReq,
  input  logic        hostWe,
  input  logic        lpReq,
  output ctrlStrobe_t strobe,
  output logic        hostAck
);

  localparam int CNT_W = $clog2(EXIT_CYC + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ACKD, ST_SRIN, ST_SR, ST_SREXIT
  } state_e;

  state_e          state, stateNxt;
  logic [CNT_W-1:0] exitCnt;
  logic             modeLive;

  assign modeLive = (modeVal != MODE_RESET);

  always_comb begin
    stateNxt       = state;
    strobe.cmd     = CMD_DESEL;
    strobe.addrSel = ADDR_ZERO;
    strobe.ckeLow  = (state == ST_SRIN) || (state == ST_SR);
    unique case (state)
      ST_IDLE: begin
        if (lpReq && modeLive) begin
          stateNxt   = ST_SRIN;
          strobe.cmd = CMD_REF;
        end else if (lpReq && !modeLive) begin
          stateNxt = ST_IDLE;
        end else if (hostReq && modeLive) begin
          stateNxt = ST_ACKD;
          unique case (modeVal)
            MODE_PRE: begin
              strobe.cmd     = CMD_PRE;
              strobe.addrSel = ADDR_A10;
            end
            MODE_MRS: begin
              strobe.cmd     = CMD_MRS;
              strobe.addrSel = ADDR_HOST;
            end
            MODE_REF: strobe.cmd = CMD_REF;
            MODE_RUN: begin
              strobe.cmd     = hostWe ? CMD_WR : CMD_RD;
              strobe.addrSel = ADDR_HOST;
            end
            default:  strobe.cmd = CMD_NOP;  // 001 and reserved 100/101
          endcase
        end
      end
      ST_ACKD:  stateNxt = ST_IDLE;
      ST_SRIN:  stateNxt = ST_SR;
      ST_SR: begin
        if (!lpReq) begin
          stateNxt   = ST_SREXIT;
          strobe.cmd = CMD_NOP;
        end
      end
      ST_SREXIT: begin
        if (exitCnt == '0) stateNxt = ST_IDLE;
        else               strobe.cmd = CMD_NOP;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      exitCnt <= '0;
    end else begin
      state <= stateNxt;
      if (state == ST_SR && !lpReq)        exitCnt <= CNT_W'(EXIT_CYC - 1);
      else if (state == ST_SREXIT && exitCnt != '0) exitCnt <= exitCnt - 1'b1;
    end
  end

  assign hostAck = (state == ST_ACKD);

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int MA_W     = 13,
  parameter int CKE_W    = 2,
  parameter int EXIT_CYC = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              hostReq,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  output logic              hostAck,
  input  logic              lpReq,
  output logic              memCsN,
  output logic              memRasN,
  output logic              memCasN,
  output logic              memWeN,
  output logic [MA_W-1:0]   memAddr,
  output logic [CKE_W-1:0]  memCke
);

  ctrlStrobe_t strobe;
  logic [2:0]  modeVal;
  logic [3:0]  cmdOut;

  sis_ctrl #(.EXIT_CYC(EXIT_CYC)) ctrl_i (
    .clk(clk), .rstN(rstN), .modeVal(modeVal), .hostReq(hostReq),
    .hostWe(hostWe), .lpReq(lpReq), .strobe(strobe), .hostAck(hostAck)
  );

  sis_datapath #(.ADDR_W(ADDR_W), .MA_W(MA_W), .CKE_W(CKE_W), .REG_W(8)) dp_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .hostAddr(hostAddr), .strobe(strobe), .modeVal(modeVal),
    .regRdData(regRdData), .cmdOut(cmdOut), .memAddr(memAddr), .memCke(memCke)
  );

  assign {memCsN, memRasN, memCasN, memWeN} = cmdOut;

endmodule

// File: rtl/sis_checker.sv
module sis_checker #(
  parameter int CKE_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [7:0]       regWrData,
  input logic [7:0]       regRdData,
  input logic             hostAck,
  input logic [3:0]       memCmd,
  input logic [CKE_W-1:0] memCke
);

  logic wasWritten;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wasWritten <= 1'b0;
    else if (regWrEn && regWrData[2:0] != 3'b000) wasWritten <= 1'b1;
  end

  AST_CKE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (memCke != '0) |-> wasWritten); // R3
  AST_CKE_UNIFORM: assert property (@(posedge clk) disable iff (!rstN)
    (memCke == '0) || (memCke == '1)); // R3
  AST_TYPE_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[5:4] == 2'b00); // R2
  AST_NO_ACK_RESET_MODE: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |-> $past(regRdData[2:0]) != 3'b000); // R4
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |=> !hostAck); // R11
  AST_ACK_WITH_CMD: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |-> memCmd != 4'b1111); // R11
  AST_SR_ENTRY_REF: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memCke[0]) |-> memCmd == 4'b0001); // R12
  AST_NO_ACK_CKE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |-> memCke[0]); // R12

endmodule

bind sdram_init_seq sis_checker #(.CKE_W(CKE_W)) chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
  .regRdData(regRdData), .hostAck(hostAck),
  .memCmd({memCsN, memRasN, memCasN, memWeN}), .memCke(memCke)
);

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb_top;

  localparam int ADDR_W = 16;
  localparam int MA_W = 13;
  localparam int CKE_W = 2;
  localparam int EXIT_CYC = 8;

  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
    C_WR = 4'b0100, C_RD = 4'b0101, C_NOP = 4'b0111, C_DES = 4'b1111;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic hostReq = 1'b0, hostWe = 1'b0, hostAck, lpReq = 1'b0;
  logic [ADDR_W-1:0] hostAddr = '0;
  logic memCsN, memRasN, memCasN, memWeN;
  logic [MA_W-1:0] memAddr;
  logic [CKE_W-1:0] memCke;
  wire [3:0] cmd = {memCsN, memRasN, memCasN, memWeN};

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sdram_init_seq #(.ADDR_W(ADDR_W), .MA_W(MA_W), .CKE_W(CKE_W), .EXIT_CYC(EXIT_CYC)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .hostReq(hostReq), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostAck(hostAck), .lpReq(lpReq), .memCsN(memCsN), .memRasN(memRasN),
    .memCasN(memCasN), .memWeN(memWeN), .memAddr(memAddr), .memCke(memCke)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic writeMode(input logic [7:0] d);
    @(negedge clk); regWrEn = 1'b1; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic doAccess(input logic we, input logic [15:0] a, input logic [3:0] eCmd,
                          input logic [12:0] eAddr, input string req);
    int n;
    @(negedge clk); hostReq = 1'b1; hostWe = we; hostAddr = a;
    n = 0;
    do begin @(negedge clk); n++; end while (!hostAck && n < 20);
    check(hostAck === 1'b1, req, "ack", hostAck, 1);
    check(cmd === eCmd, req, "command", cmd, eCmd);
    check(memAddr === eAddr, req, "address", memAddr, eAddr);
    hostReq = 1'b0;
    @(negedge clk);
    check(hostAck === 1'b0 && cmd === C_DES, "R11", "after ack", {hostAck, cmd}, {1'b0, C_DES});
  endtask

  task automatic tReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(memCke === '0, "R1", "cke in reset", memCke, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(regRdData === 8'h00, "R1", "readback", regRdData, 8'h00);
    check(memCke === '0, "R1", "cke", memCke, 0);
    check(cmd === C_DES, "R1", "command", cmd, C_DES);
    check(hostAck === 1'b0, "R1", "ack", hostAck, 0);
  endtask

  task automatic tStallAndEnable();
    @(negedge clk); hostReq = 1'b1; hostAddr = 16'h0040;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(hostAck === 1'b0 && cmd === C_DES, "R4", "stall in 000", {hostAck, cmd}, {1'b0, C_DES});
      check(memCke === '0, "R3", "cke before write", memCke, 0);
    end
    hostReq = 1'b0;
    writeMode(8'h00);
    check(memCke === '0, "R3", "cke after zero write", memCke, 0);
    @(negedge clk); regWrEn = 1'b1; regWrData = 8'h01;
    @(negedge clk); regWrEn = 1'b0;
    check(memCke === '1, "R3", "cke after nonzero write", memCke, {CKE_W{1'b1}});
    writeMode(8'h00);
    check(memCke === '1, "R3", "cke sticky", memCke, {CKE_W{1'b1}});
  endtask

  task automatic tReadback();
    writeMode(8'hF6);
    check(regRdData === 8'h06, "R2", "type field read-only", regRdData, 8'h06);
  endtask

  task automatic tModes();
    writeMode(8'h01); doAccess(1'b0, 16'hFFF8, C_NOP, 13'h0000, "R5");
    writeMode(8'h02); doAccess(1'b0, 16'h1238, C_PRE, 13'h0400, "R6");
    writeMode(8'h03); doAccess(1'b1, 16'hABC8, C_MRS, 13'h1579, "R7");
    writeMode(8'h03); doAccess(1'b0, 16'h0118, C_MRS, 13'h0023, "R7");
    writeMode(8'h06); doAccess(1'b0, 16'h5550, C_REF, 13'h0000, "R8");
    writeMode(8'h04); doAccess(1'b0, 16'h7777, C_NOP, 13'h0000, "R10");
    writeMode(8'h05); doAccess(1'b1, 16'h7777, C_NOP, 13'h0000, "R10");
    writeMode(8'h07); doAccess(1'b0, 16'h1238, C_RD, 13'h0247, "R9");
    doAccess(1'b1, 16'hFFFF, C_WR, 13'h1FFF, "R9");
  endtask

  task automatic tSelfRefresh();
    writeMode(8'h07);
    @(negedge clk); lpReq = 1'b1; hostReq = 1'b1; hostWe = 1'b0; hostAddr = 16'h0808;
    @(negedge clk);
    check(cmd === C_REF, "R12", "entry command", cmd, C_REF);
    check(memCke === '0, "R12", "entry cke", memCke, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(cmd === C_DES && memCke === '0 && hostAck === 1'b0, "R12", "held in self-refresh",
            {hostAck, memCke, cmd}, {1'b0, {CKE_W{1'b0}}, C_DES});
    end
    lpReq = 1'b0;
    for (int i = 0; i < EXIT_CYC; i++) begin
      @(negedge clk);
      check(cmd === C_NOP && memCke === '1 && hostAck === 1'b0, "R13", "exit nop run",
            {hostAck, memCke, cmd}, {1'b0, {CKE_W{1'b1}}, C_NOP});
    end
    @(negedge clk);
    check(hostAck === 1'b0 && cmd === C_DES, "R13", "idle after exit", {hostAck, cmd}, {1'b0, C_DES});
    @(negedge clk);
    check(hostAck === 1'b1 && cmd === C_RD && memAddr === 13'h0101, "R13", "pending read",
          {hostAck, cmd, 3'b0, memAddr}, {1'b1, C_RD, 3'b0, 13'h0101});
    hostReq = 1'b0;
    @(negedge clk);
  endtask

  task automatic tResetInSr();
    @(negedge clk); lpReq = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); lpReq = 1'b0;
    repeat (4) @(negedge clk);
    check(regRdData[2:0] === 3'b000, "R14", "mode after resume reset", regRdData[2:0], 0);
    check(memCke === '0, "R14", "cke after resume reset", memCke, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tReset();
    tStallAndEnable();
    tReadback();
    tModes();
    tSelfRefresh();
    tResetInSr();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule